// File: doc/BRIEF.md
# Linear Photodiode Array Readout Sequencer

This block paces the readout of a 64-pixel linear image sensor. It makes the sensor clock by dividing the system clock. It places a start pulse so that exactly one rising sensor-clock edge captures it. It then counts pixel clocks, and after the last pixel it adds the terminating clock that returns the sensor to a known state. The next start pulse comes only after a programmable number of sensor clocks. That spacing is the exposure time of the following frame.

For each pixel the block gives the external converter a one-cycle sample strobe and a 6-bit pixel index. The strobe comes a fixed number of system clocks after the sensor-clock edge that selects the pixel. The converter cannot hold off the sensor, because a pixel selected by the clock is gone at the next edge. The strobe/index pair is therefore a valid-only stream with no ready and no back-pressure: a sampler must take every strobe in the cycle it appears. The first frame after reset carries stale charge, so its strobes are suppressed.

Top module: `lsa_readout_seq`

## Requirements
- R1: While reset is held, and after it until enable is seen high, the sensor clock, start line, strobe, frame-done and pixel index are all low.
- R2: While running, the sensor clock has a period of CLK_DIV system clocks and stays high for CLK_DIV/2 of them after each rising edge.
- R3: The start line changes only while the sensor clock is low, and each start pulse is high across exactly one rising sensor-clock edge.
- R4: A new start is captured only after the 65th rising edge of the current frame, the start edge being edge 1.
- R5: With enable held high, consecutive start edges are max(expo_len, 66) sensor clocks apart. expo_len is taken at the start edge and applies to that frame's spacing only.
- R6: For the start edge and the 63 edges after it, the strobe is high for one system clock, SETTLE system clocks after that edge. pix_idx gives that edge's pixel number, 0 for the start edge rising to 63. No strobe occurs at any other time.
- R7: The first frame after reset produces no strobes. Later frames produce 64.
- R8: When enable is low, a running frame still gets its 65th edge. The sensor clock and start line then stay low, and no start is raised. When enable goes high from idle, the start line rises one system clock later, and the capturing edge follows CLK_DIV/2 system clocks after that.
- R9: frame_done is high for exactly one system clock per frame, in the cycle in which the sensor clock first reads high after the 65th edge, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run request; sampled at frame boundaries and in idle |
| expo_len | input | LEN_W | Start-to-start spacing in sensor clocks (floor 66) |
| sen_si | output | 1 | Start pulse to the sensor |
| sen_clk | output | 1 | Sensor clock |
| adc_strobe | output | 1 | One-cycle sample strobe to the converter (valid, no ready) |
| pix_idx | output | 6 | Pixel number for the current strobe |
| frame_done | output | 1 | One-cycle pulse after the terminating edge |

## Verification
Every result is tied to the system cycle in which a sensor-clock rising edge first reads high. frame_done is due in that same cycle. The strobe is due exactly SETTLE cycles later. The start line rises one cycle after enable is taken from idle, and the capturing edge follows CLK_DIV/2 cycles after that. The bench samples on the falling system edge and drives inputs just after the rising edge. It records the cycle of each observed rising edge and compares each strobe, index and done pulse against that recorded cycle plus the fixed offset. For the spacing check it uses the expo_len value held at the capturing edge, since that is the value the design latches.

// File: rtl/lsa_pkg.sv
package lsa_pkg;
  // pixels per frame; one sensor clock per pixel
  localparam int unsigned NPIX      = 64;
  localparam int unsigned IDX_W     = $clog2(NPIX);
  // 0-based edge count (start edge = 0) at which the terminating edge has occurred
  localparam int unsigned TERM_EDGE = NPIX;
  // smallest legal start-to-start spacing in sensor clocks
  localparam int unsigned MIN_GAP   = NPIX + 2;

  typedef enum logic {ST_IDLE, ST_RUN} seq_state_t;
endpackage

// File: rtl/lsa_clkgen.sv
module lsa_clkgen #(
  parameter int unsigned CLK_DIV = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        run,
  output logic                        sen_clk,
  output logic                        rise,
  output logic                        fall,
  output logic [$clog2(CLK_DIV)-1:0]  phase
);
  localparam int unsigned PH_W = $clog2(CLK_DIV);
  localparam int unsigned HALF = CLK_DIV / 2;
  localparam logic [PH_W-1:0] PH_LAST     = PH_W'(CLK_DIV - 1);
  localparam logic [PH_W-1:0] PH_HALF     = PH_W'(HALF);
  localparam logic [PH_W-1:0] PH_PRE_FALL = PH_W'(HALF - 1);

  logic [PH_W-1:0] ph_q, ph_nxt;
  logic            clk_q;

  // parked at the start of the low half so a restart begins with a low phase
  always_comb begin
    if (!run)                 ph_nxt = PH_HALF;
    else if (ph_q == PH_LAST) ph_nxt = '0;
    else                      ph_nxt = ph_q + PH_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q  <= PH_HALF;
      clk_q <= 1'b0;
    end else begin
      ph_q  <= ph_nxt;
      clk_q <= run && (ph_nxt < PH_HALF);
    end
  end

  assign rise    = run && (ph_q == PH_LAST);
  assign fall    = run && (ph_q == PH_PRE_FALL);
  assign sen_clk = clk_q;
  assign phase   = ph_q;

  AST_RISE_HIGH: assert property (@(posedge clk) disable iff (!rst_n) rise |=> clk_q);   // R2
  AST_FALL_LOW:  assert property (@(posedge clk) disable iff (!rst_n) fall |=> !clk_q);  // R2
  AST_PARK_LOW:  assert property (@(posedge clk) disable iff (!rst_n) !run |=> !clk_q);  // R8
endmodule

// File: rtl/lsa_frame_ctl.sv
module lsa_frame_ctl
  import lsa_pkg::*;
#(
  parameter int unsigned LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [LEN_W-1:0] expo_len,
  input  logic             rise,
  input  logic             fall,
  output logic             run,
  output logic             si,
  output logic [LEN_W-1:0] edge_idx,
  output logic             flush,
  output logic             done
);
  localparam logic [LEN_W-1:0] TERM  = LEN_W'(TERM_EDGE);
  localparam logic [LEN_W-1:0] FLOOR = LEN_W'(MIN_GAP);

  seq_state_t       state_q;
  logic [LEN_W-1:0] cnt_q, len_q, len_clamp;
  logic             si_q, flush_q, done_q;

  assign len_clamp = (expo_len < FLOOR) ? FLOOR : expo_len;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= TERM;
      len_q   <= FLOOR;
      si_q    <= 1'b0;
      flush_q <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (enable) begin
            state_q <= ST_RUN;
            si_q    <= 1'b1;
          end
        end
        default: begin
          if (rise) begin
            if (si_q) begin
              cnt_q <= '0;
              len_q <= len_clamp;
            end else begin
              cnt_q <= cnt_q + LEN_W'(1);
              if (cnt_q == TERM - LEN_W'(1)) begin
                done_q  <= 1'b1;
                flush_q <= 1'b0;
              end
            end
          end
          if (fall) begin
            if (si_q) begin
              si_q <= 1'b0;
            end else if (cnt_q >= TERM) begin
              if (!enable)                          state_q <= ST_IDLE;
              else if (cnt_q == len_q - LEN_W'(1))  si_q    <= 1'b1;
            end
          end
        end
      endcase
    end
  end

  assign run      = (state_q == ST_RUN);
  assign si       = si_q;
  assign edge_idx = cnt_q;
  assign flush    = flush_q;
  assign done     = done_q;

  AST_START_AFTER_TERM: assert property (@(posedge clk) disable iff (!rst_n) (rise && si_q) |-> (cnt_q >= TERM)); // R4
  AST_DONE_PULSE:       assert property (@(posedge clk) disable iff (!rst_n) done_q |=> !done_q);                 // R9
  AST_IDLE_SI_LOW:      assert property (@(posedge clk) disable iff (!rst_n) (state_q == ST_IDLE) |-> !si_q);    // R8
  AST_LEN_FLOOR:        assert property (@(posedge clk) disable iff (!rst_n) len_q >= FLOOR);                     // R5
endmodule

// File: rtl/lsa_strobe_gen.sv
module lsa_strobe_gen
  import lsa_pkg::*;
#(
  parameter int unsigned CLK_DIV = 4,
  parameter int unsigned SETTLE  = 1,
  parameter int unsigned LEN_W   = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       run,
  input  logic [$clog2(CLK_DIV)-1:0] phase,
  input  logic [LEN_W-1:0]           edge_idx,
  input  logic                       flush,
  output logic                       strobe,
  output logic [IDX_W-1:0]           pix_idx
);
  localparam int unsigned PH_W = $clog2(CLK_DIV);
  localparam logic [PH_W-1:0]  PH_HIT = PH_W'(SETTLE - 1);
  localparam logic [LEN_W-1:0] TERM   = LEN_W'(TERM_EDGE);

  logic             strobe_q, strobe_nxt;
  logic [IDX_W-1:0] idx_q;

  // phase restarts at 0 on the selecting edge, so PH_HIT lands SETTLE cycles after it
  assign strobe_nxt = run && (phase == PH_HIT) && (edge_idx < TERM) && !flush;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      idx_q    <= '0;
    end else begin
      strobe_q <= strobe_nxt;
      if (strobe_nxt) idx_q <= edge_idx[IDX_W-1:0];
    end
  end

  assign strobe  = strobe_q;
  assign pix_idx = idx_q;

  AST_STROBE_PULSE:    assert property (@(posedge clk) disable iff (!rst_n) strobe_q |=> !strobe_q); // R6
  AST_FLUSH_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n) flush |-> !strobe_q);    // R7
endmodule

// File: rtl/lsa_readout_seq.sv
module lsa_readout_seq
  import lsa_pkg::*;
#(
  parameter int unsigned CLK_DIV = 4,
  parameter int unsigned SETTLE  = 1,
  parameter int unsigned LEN_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [LEN_W-1:0] expo_len,
  output logic             sen_si,
  output logic             sen_clk,
  output logic             adc_strobe,
  output logic [5:0]       pix_idx,
  output logic             frame_done
);
  localparam int unsigned PH_W = $clog2(CLK_DIV);

  logic             run, rise, fall, flush;
  logic [PH_W-1:0]  phase;
  logic [LEN_W-1:0] edge_idx;

  lsa_clkgen #(.CLK_DIV(CLK_DIV)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(run),
    .sen_clk(sen_clk), .rise(rise), .fall(fall), .phase(phase)
  );

  lsa_frame_ctl #(.LEN_W(LEN_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .enable(enable), .expo_len(expo_len),
    .rise(rise), .fall(fall), .run(run), .si(sen_si),
    .edge_idx(edge_idx), .flush(flush), .done(frame_done)
  );

  lsa_strobe_gen #(.CLK_DIV(CLK_DIV), .SETTLE(SETTLE), .LEN_W(LEN_W)) u_stb (
    .clk(clk), .rst_n(rst_n), .run(run), .phase(phase),
    .edge_idx(edge_idx), .flush(flush),
    .strobe(adc_strobe), .pix_idx(pix_idx)
  );

  AST_SI_CLK_LOW:   assert property (@(posedge clk) disable iff (!rst_n)
                      (sen_si != $past(sen_si)) |-> !sen_clk);                    // R3
  AST_DONE_CLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
                      frame_done |-> sen_clk);                                     // R9
endmodule

// File: tb/lsa_readout_seq_test.sv
module lsa_readout_seq_test;
  localparam int DIV = 4, HALF = 2, SETTLE = 1, LW = 8;

  logic          clk = 1'b0, rst_n = 1'b0, enable = 1'b0;
  logic [LW-1:0] expo_len = '0;
  logic          sen_si, sen_clk, adc_strobe, frame_done;
  logic [5:0]    pix_idx;

  always #5 clk = ~clk;

  lsa_readout_seq #(.CLK_DIV(DIV), .SETTLE(SETTLE), .LEN_W(LW)) uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .expo_len(expo_len),
    .sen_si(sen_si), .sen_clk(sen_clk), .adc_strobe(adc_strobe),
    .pix_idx(pix_idx), .frame_done(frame_done)
  );

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor state
  int cyc = 0, last_rise = 0, e = 64, rs = 0, gap = 66, frames = 0;
  int strobes = 0, si_rises = 0, done_cnt = 0, prev_len = 0;
  bit pclk = 0, psi = 0, cont = 0, flushf = 1, prev_en = 0;

  always @(negedge clk) begin
    bit rise_ev, fall_ev;
    cyc++;
    rise_ev = sen_clk && !pclk;
    fall_ev = !sen_clk && pclk;
    if (!rst_n) begin
      e = 64; rs = 0; frames = 0; strobes = 0; si_rises = 0;
      cont = 0; flushf = 1; last_rise = cyc;
    end else begin
      if (sen_si != psi) chk(!sen_clk, "R3 start line moved while clock high", sen_clk, 0);
      if (sen_si && !psi) begin
        chk(prev_en, "R8 start raised while disabled", prev_en, 1);
        si_rises = 0;
      end
      if (fall_ev) chk(cyc - last_rise == HALF, "R2 high time", cyc - last_rise, HALF);
      if (rise_ev) begin
        if (cont) chk(cyc - last_rise == DIV, "R2 period", cyc - last_rise, DIV);
        rs++;
        if (sen_si) begin
          si_rises++;
          chk(e >= 64, "R4 start before terminating edge", e, 64);
          if (cont) chk(rs == gap, "R5 start spacing", rs, gap);
          gap = (prev_len < 66) ? 66 : prev_len;
          rs = 0; e = 0; strobes = 0;
          flushf = (frames == 0);
          frames++;
          cont = 1;
        end else begin
          e++;
        end
        chk(frame_done == (e == 64), "R9 done at 65th edge", frame_done, e == 64);
        last_rise = cyc;
      end else begin
        if (frame_done) chk(0, "R9 done away from edge", 1, 0);
        if (cyc - last_rise > DIV) cont = 0;
      end
      if (adc_strobe) begin
        chk(cyc == last_rise + SETTLE && e < 64 && !flushf, "R6 strobe placement",
            cyc - last_rise, SETTLE);
        chk(pix_idx == e[5:0], "R6 pixel index", pix_idx, e);
        strobes++;
      end
      if (frame_done) begin
        done_cnt++;
        chk(strobes == (flushf ? 0 : 64), "R7 strobes per frame", strobes, flushf ? 0 : 64);
      end
      if (psi && !sen_si) chk(si_rises == 1, "R3 edges under start pulse", si_rises, 1);
    end
    pclk = sen_clk; psi = sen_si; prev_len = int'(expo_len); prev_en = enable;
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check_quiet(input string req, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      chk(!sen_clk && !sen_si && !adc_strobe && !frame_done, req,
          {sen_clk, sen_si, adc_strobe, frame_done}, 0);
    end
  endtask

  initial begin
    int lens[8] = '{0, 40, 65, 66, 67, 80, 130, 255};
    int dc;
    // reset state
    wait_cyc(3);
    chk(!sen_clk && !sen_si && !adc_strobe && !frame_done && pix_idx == 0,
        "R1 outputs during reset", {sen_clk, sen_si, adc_strobe, frame_done}, 0);
    rst_n = 1'b1;
    check_quiet("R1 idle after reset", 20);

    // sweep of spacing settings, enable held high
    @(posedge clk); #1;
    enable = 1'b1;
    @(posedge clk); #1;
    chk(sen_si && !sen_clk, "R8 start one cycle after enable", sen_si, 1);
    repeat (HALF) @(posedge clk);
    #1;
    chk(sen_clk && sen_si, "R8 capture edge half a period later", sen_clk, 1);
    for (int i = 0; i < 8; i++) begin
      expo_len = LW'(lens[i]);
      wait_cyc(((lens[i] < 66) ? 66 : lens[i]) * DIV * 3);
    end

    // disable mid-frame: frame completes, then quiet
    expo_len = LW'(70);
    wait_cyc(70 * DIV * 2);
    dc = done_cnt;
    wait_cyc(20 * DIV);
    enable = 1'b0;
    wait_cyc(300 * DIV);
    chk(done_cnt == dc + 1, "R8 running frame finishes", done_cnt, dc + 1);
    check_quiet("R8 quiet while disabled", 60);

    // re-enable, then reset mid-frame to see a new flush frame
    @(posedge clk); #1;
    enable = 1'b1;
    wait_cyc(70 * DIV * 2 + 30 * DIV);
    rst_n = 1'b0;
    wait_cyc(3);
    chk(!sen_clk && !sen_si && !adc_strobe && !frame_done, "R1 outputs in mid-run reset",
        {sen_clk, sen_si, adc_strobe, frame_done}, 0);
    rst_n = 1'b1;
    dc = done_cnt;
    wait_cyc(70 * DIV * 3 + 10);
    chk(done_cnt == dc + 3, "R7 frames after reset", done_cnt, dc + 3);
    enable = 1'b0;
    wait_cyc(200 * DIV);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule